// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block takes one inter-processor interrupt request and works out which of up to eight processor units receive it. A request carries a destination value, an addressing mode (physical or flat logical), a two-bit shorthand, the sending unit's ID and a delivery mode. Each unit also supplies its own logical destination register to the block. The result is a bitmask with one bit per unit, where bit i stands for the unit whose ID is i.

The block also raises a flag when every unit is to run its INIT sequence, so that case is kept apart from ordinary targeted delivery. A third output names the units that must copy their own ID into their arbitration ID when an INIT de-assert arrives. All three results are registered. They appear one cycle after a request strobe and stay unchanged until the next strobe.

Top module: `ipi_dest_resolver`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_mask, out_arb_load and out_init_all are all 0 until the first request is captured.
- R2: A request presented with req_valid high at a rising clock edge produces its results with out_valid high after that edge. out_valid is low after any edge where req_valid is low, and all result outputs then keep their previous values.
- R3: With shorthand 0 and physical addressing (req_logical = 0), destination 0xFF selects every unit. A destination equal to a unit's index selects only that unit, and any other destination (8 to 0xFE) selects none.
- R4: With shorthand 0 and flat logical addressing (req_logical = 1), unit i is selected when the bitwise AND of req_dest and its logical register is nonzero. Unit i's register is unit_ldr[8i+7:8i].
- R5: Shorthand 1 selects only the sender, and selects no unit if the sender ID is 8 or more. Shorthand 2 selects all units. Shorthand 3 selects all units except the sender. In each case the destination value is ignored.
- R6: Delivery mode 0 (fixed) puts the selected units on out_mask, with out_init_all = 0 and out_arb_load = 0.
- R7: Delivery mode 1 (lowest priority) replaces req_dest with req_sender before addressing, then behaves as fixed mode.
- R8: Delivery mode 5 (INIT), when it is not a de-assert, sets out_mask to all ones and out_init_all to 1, whatever the addressing fields select, with out_arb_load = 0.
- R9: An INIT request with req_level = 0 and req_trigger = 1 is a de-assert. It gives out_mask = 0 and out_init_all = 0, and out_arb_load equal to the units the addressing fields select.
- R10: Delivery modes 2, 3, 4, 6 and 7 give out_mask = 0, out_arb_load = 0 and out_init_all = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_dest | input | 8 | Destination ID or logical destination bits |
| req_logical | input | 1 | 0 = physical addressing, 1 = flat logical addressing |
| req_shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but self |
| req_sender | input | 8 | ID of the sending unit |
| req_mode | input | 3 | Delivery mode: 0 fixed, 1 lowest priority, 5 INIT, others unsupported |
| req_level | input | 1 | Level bit of the request |
| req_trigger | input | 1 | Trigger bit of the request (1 = level) |
| unit_ldr | input | 64 | Logical destination registers of the units, 8 bits per unit |
| out_valid | output | 1 | Results were captured at the last edge |
| out_mask | output | 8 | Units that receive the interrupt |
| out_arb_load | output | 8 | Units that load their arbitration ID from their own ID |
| out_init_all | output | 1 | Broadcast INIT to every unit |

## Verification
The assertions assume that the request fields and unit_ldr hold stable during the cycle in which req_valid is high. They also assume req_valid is low throughout reset, because their checks compare results against the request captured one edge earlier. The bench drives every input on the falling edge and keeps req_valid high for exactly one rising edge per request, with reset held and req_valid low before the first request. Sender IDs and destinations of 8 or more are applied on purpose, since addressing must give them defined results.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_RSV2   = 3'd2,
    DM_RSV3   = 3'd3,
    DM_RSV4   = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV6   = 3'd6,
    DM_RSV7   = 3'd7
  } deliv_mode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match #(
  parameter int DEST_W   = 8,
  parameter int UNIT_IDX = 0
) (
  input  logic [DEST_W-1:0] dest_i,
  input  logic              logical_i,
  input  logic [DEST_W-1:0] ldr_i,
  output logic              hit_o
);

  logic phys_hit;
  logic log_hit;

  always_comb begin
    phys_hit = (dest_i == DEST_W'(UNIT_IDX));
    log_hit  = |(dest_i & ldr_i);
    hit_o    = logical_i ? log_hit : phys_hit;
  end

endmodule

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode #(
  parameter int NUM_UNITS = 8,
  parameter int DEST_W    = 8
) (
  input  logic [DEST_W-1:0]           dest_i,
  input  logic                        logical_i,
  input  logic [NUM_UNITS*DEST_W-1:0] ldr_i,
  output logic [NUM_UNITS-1:0]        addr_mask_o
);

  localparam logic [DEST_W-1:0] BCAST = {DEST_W{1'b1}};

  logic [NUM_UNITS-1:0] unit_hit;
  logic                 phys_bcast;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    ipi_unit_match #(
      .DEST_W  (DEST_W),
      .UNIT_IDX(u)
    ) u_match (
      .dest_i   (dest_i),
      .logical_i(logical_i),
      .ldr_i    (ldr_i[u*DEST_W +: DEST_W]),
      .hit_o    (unit_hit[u])
    );
  end

  always_comb begin
    phys_bcast  = !logical_i && (dest_i == BCAST);
    addr_mask_o = phys_bcast ? {NUM_UNITS{1'b1}} : unit_hit;
  end

endmodule

// File: rtl/ipi_shorthand_sel.sv
module ipi_shorthand_sel
  import ipi_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int DEST_W    = 8
) (
  input  logic [1:0]           shorthand_i,
  input  logic [DEST_W-1:0]    sender_i,
  input  logic [NUM_UNITS-1:0] addr_mask_i,
  output logic [NUM_UNITS-1:0] target_o
);

  logic [NUM_UNITS-1:0] self_mask;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_self
    assign self_mask[u] = (sender_i == DEST_W'(u));
  end

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_NONE:   target_o = addr_mask_i;
      SH_SELF:   target_o = self_mask;
      SH_ALL:    target_o = {NUM_UNITS{1'b1}};
      SH_OTHERS: target_o = ~self_mask;
      default:   target_o = '0;
    endcase
  end

endmodule

// File: rtl/ipi_mode_ctl.sv
module ipi_mode_ctl
  import ipi_pkg::*;
#(
  parameter int NUM_UNITS = 8
) (
  input  logic [2:0]           mode_i,
  input  logic                 level_i,
  input  logic                 trigger_i,
  input  logic [NUM_UNITS-1:0] target_i,
  output logic [NUM_UNITS-1:0] deliver_o,
  output logic [NUM_UNITS-1:0] arb_load_o,
  output logic                 init_all_o
);

  logic deassert;

  always_comb begin
    deassert   = !level_i && trigger_i;
    deliver_o  = '0;
    arb_load_o = '0;
    init_all_o = 1'b0;
    case (deliv_mode_e'(mode_i))
      DM_FIXED, DM_LOWPRI: deliver_o = target_i;
      DM_INIT: begin
        if (deassert) begin
          arb_load_o = target_i;
        end else begin
          deliver_o  = {NUM_UNITS{1'b1}};
          init_all_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int DEST_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [DEST_W-1:0]           req_dest,
  input  logic                        req_logical,
  input  logic [1:0]                  req_shorthand,
  input  logic [DEST_W-1:0]           req_sender,
  input  logic [2:0]                  req_mode,
  input  logic                        req_level,
  input  logic                        req_trigger,
  input  logic [NUM_UNITS*DEST_W-1:0] unit_ldr,
  output logic                        out_valid,
  output logic [NUM_UNITS-1:0]        out_mask,
  output logic [NUM_UNITS-1:0]        out_arb_load,
  output logic                        out_init_all
);

  logic [DEST_W-1:0]    eff_dest;
  logic [NUM_UNITS-1:0] addr_mask;
  logic [NUM_UNITS-1:0] target;
  logic [NUM_UNITS-1:0] deliver_c;
  logic [NUM_UNITS-1:0] arb_c;
  logic                 init_c;

  logic [NUM_UNITS-1:0] mask_q,  mask_d;
  logic [NUM_UNITS-1:0] arb_q,   arb_d;
  logic                 init_q,  init_d;
  logic                 valid_q, valid_d;

  always_comb begin
    eff_dest = (deliv_mode_e'(req_mode) == DM_LOWPRI) ? req_sender : req_dest;
  end

  ipi_addr_decode #(
    .NUM_UNITS(NUM_UNITS),
    .DEST_W   (DEST_W)
  ) u_decode (
    .dest_i     (eff_dest),
    .logical_i  (req_logical),
    .ldr_i      (unit_ldr),
    .addr_mask_o(addr_mask)
  );

  ipi_shorthand_sel #(
    .NUM_UNITS(NUM_UNITS),
    .DEST_W   (DEST_W)
  ) u_short (
    .shorthand_i(req_shorthand),
    .sender_i   (req_sender),
    .addr_mask_i(addr_mask),
    .target_o   (target)
  );

  ipi_mode_ctl #(
    .NUM_UNITS(NUM_UNITS)
  ) u_mode (
    .mode_i    (req_mode),
    .level_i   (req_level),
    .trigger_i (req_trigger),
    .target_i  (target),
    .deliver_o (deliver_c),
    .arb_load_o(arb_c),
    .init_all_o(init_c)
  );

  always_comb begin
    valid_d = req_valid;
    mask_d  = mask_q;
    arb_d   = arb_q;
    init_d  = init_q;
    if (req_valid) begin
      mask_d = deliver_c;
      arb_d  = arb_c;
      init_d = init_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      arb_q   <= '0;
      init_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
      arb_q   <= arb_d;
      init_q  <= init_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_mask     = mask_q;
  assign out_arb_load = arb_q;
  assign out_init_all = init_q;

endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
  parameter int NUM_UNITS = 8,
  parameter int DEST_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [DEST_W-1:0]    req_dest,
  input logic                 req_logical,
  input logic [1:0]           req_shorthand,
  input logic [DEST_W-1:0]    req_sender,
  input logic [2:0]           req_mode,
  input logic                 req_level,
  input logic                 req_trigger,
  input logic                 out_valid,
  input logic [NUM_UNITS-1:0] out_mask,
  input logic [NUM_UNITS-1:0] out_arb_load,
  input logic                 out_init_all
);

  localparam logic [NUM_UNITS-1:0] ONE = NUM_UNITS'(1);

  // R2: results follow a strobe by one edge
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R2: idle edges clear valid and hold the results
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && $stable(out_mask) && $stable(out_arb_load)
                   && $stable(out_init_all));

  // R3: physical single-unit addressing in fixed mode
  a_r3_phys_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd0 && req_shorthand == 2'd0 && !req_logical
     && req_dest < DEST_W'(NUM_UNITS))
    |=> out_mask == (ONE << $past(req_dest)));

  // R5: all-but-self never includes the sender
  a_r5_others_no_self: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd0 && req_shorthand == 2'd3
     && req_sender < DEST_W'(NUM_UNITS))
    |=> (out_mask & (ONE << $past(req_sender))) == '0);

  // R7: lowest priority with physical addressing reaches the sender only
  a_r7_lowpri_sender: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd1 && req_shorthand == 2'd0 && !req_logical
     && req_sender < DEST_W'(NUM_UNITS))
    |=> out_mask == (ONE << $past(req_sender)));

  // R8: a non-de-assert INIT reaches every unit
  a_r8_init_all: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd5 && !(!req_level && req_trigger))
    |=> out_init_all && (&out_mask) && out_arb_load == '0);

  // R9: a de-assert INIT delivers nothing
  a_r9_deassert_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'd5 && !req_level && req_trigger)
    |=> out_mask == '0 && !out_init_all);

  // R10: unsupported modes produce nothing
  a_r10_unlisted_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode != 3'd0 && req_mode != 3'd1 && req_mode != 3'd5)
    |=> out_mask == '0 && out_arb_load == '0 && !out_init_all);

endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(
  .NUM_UNITS(NUM_UNITS),
  .DEST_W   (DEST_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_dest     (req_dest),
  .req_logical  (req_logical),
  .req_shorthand(req_shorthand),
  .req_sender   (req_sender),
  .req_mode     (req_mode),
  .req_level    (req_level),
  .req_trigger  (req_trigger),
  .out_valid    (out_valid),
  .out_mask     (out_mask),
  .out_arb_load (out_arb_load),
  .out_init_all (out_init_all)
);

// File: tb/ipi_dest_resolver_test.sv
module ipi_dest_resolver_test;

  localparam int N = 8;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic [W-1:0] req_dest;
  logic         req_logical;
  logic [1:0]   req_shorthand;
  logic [W-1:0] req_sender;
  logic [2:0]   req_mode;
  logic         req_level;
  logic         req_trigger;
  logic [N*W-1:0] unit_ldr;
  logic         out_valid;
  logic [N-1:0] out_mask;
  logic [N-1:0] out_arb_load;
  logic         out_init_all;

  int n_checks;
  int n_fails;
  int cycles;

  ipi_dest_resolver #(.NUM_UNITS(N), .DEST_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_shorthand(req_shorthand),
    .req_sender(req_sender), .req_mode(req_mode), .req_level(req_level),
    .req_trigger(req_trigger), .unit_ldr(unit_ldr), .out_valid(out_valid),
    .out_mask(out_mask), .out_arb_load(out_arb_load),
    .out_init_all(out_init_all)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fails++;
        $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
        summary();
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Units selected by the addressing fields (R3, R4, R5, R7)
  function automatic logic [N-1:0] sel_units(logic [W-1:0] d, logic lg,
                                             logic [1:0] sh, logic [W-1:0] snd,
                                             logic [2:0] md);
    logic [N-1:0] m;
    logic [W-1:0] dd;
    m  = '0;
    dd = (md == 3'd1) ? snd : d;
    for (int i = 0; i < N; i++) begin
      case (sh)
        2'd0: begin
          if (lg) m[i] = ((dd & unit_ldr[i*W +: W]) != 0);
          else    m[i] = (dd == 8'hFF) || (int'(dd) == i);
        end
        2'd1: m[i] = (int'(snd) == i);
        2'd2: m[i] = 1'b1;
        default: m[i] = (int'(snd) != i);
      endcase
    end
    return m;
  endfunction

  task automatic apply(string req, logic [W-1:0] d, logic lg, logic [1:0] sh,
                       logic [W-1:0] snd, logic [2:0] md, logic lv, logic tr);
    logic [N-1:0] sel;
    logic [N-1:0] e_mask;
    logic [N-1:0] e_arb;
    logic         e_init;
    sel    = sel_units(d, lg, sh, snd, md);
    e_mask = '0;
    e_arb  = '0;
    e_init = 1'b0;
    if (md == 3'd0 || md == 3'd1) begin
      e_mask = sel;
    end else if (md == 3'd5) begin
      if (!lv && tr) e_arb = sel;
      else begin
        e_mask = '1;
        e_init = 1'b1;
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_dest = d; req_logical = lg; req_shorthand = sh;
    req_sender = snd; req_mode = md; req_level = lv; req_trigger = tr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "valid", 32'(out_valid), 32'd1);
    chk(req, "mask", 32'(out_mask), 32'(e_mask));
    chk(req, "arb_load", 32'(out_arb_load), 32'(e_arb));
    chk(req, "init_all", 32'(out_init_all), 32'(e_init));
  endtask

  task automatic t_reset();
    // R1
    chk("R1", "valid", 32'(out_valid), 32'd0);
    chk("R1", "mask", 32'(out_mask), 32'd0);
    chk("R1", "arb_load", 32'(out_arb_load), 32'd0);
    chk("R1", "init_all", 32'(out_init_all), 32'd0);
  endtask

  task automatic t_physical();
    // R3 / R6: fixed mode physical addressing
    apply("R3", 8'd3, 1'b0, 2'd0, 8'd0, 3'd0, 1'b1, 1'b0);
    apply("R3", 8'd0, 1'b0, 2'd0, 8'd5, 3'd0, 1'b1, 1'b0);
    apply("R3", 8'hFF, 1'b0, 2'd0, 8'd1, 3'd0, 1'b1, 1'b0);
    apply("R3", 8'd9, 1'b0, 2'd0, 8'd1, 3'd0, 1'b1, 1'b0);
    apply("R6", 8'd7, 1'b0, 2'd0, 8'd2, 3'd0, 1'b0, 1'b1);
    chk("R6", "mask_exact", 32'(out_mask), 32'h80);
  endtask

  task automatic t_logical();
    // R4: flat logical match
    for (int i = 0; i < N; i++) unit_ldr[i*W +: W] = 8'(1 << i);
    unit_ldr[7*W +: W] = 8'h81;
    apply("R4", 8'h05, 1'b1, 2'd0, 8'd0, 3'd0, 1'b1, 1'b0);
    chk("R4", "mask_exact", 32'(out_mask), 32'h85);
    apply("R4", 8'h00, 1'b1, 2'd0, 8'd0, 3'd0, 1'b1, 1'b0);
    apply("R4", 8'hFF, 1'b1, 2'd0, 8'd0, 3'd0, 1'b1, 1'b0);
  endtask

  task automatic t_shorthand();
    // R5: destination ignored under shorthands
    apply("R5", 8'hFF, 1'b0, 2'd1, 8'd2, 3'd0, 1'b1, 1'b0);
    chk("R5", "self_exact", 32'(out_mask), 32'h04);
    apply("R5", 8'd9, 1'b0, 2'd2, 8'd2, 3'd0, 1'b1, 1'b0);
    apply("R5", 8'd7, 1'b0, 2'd3, 8'd7, 3'd0, 1'b1, 1'b0);
    chk("R5", "others_exact", 32'(out_mask), 32'h7F);
    apply("R5", 8'd0, 1'b0, 2'd1, 8'd12, 3'd0, 1'b1, 1'b0);
    apply("R5", 8'd0, 1'b0, 2'd3, 8'd12, 3'd0, 1'b1, 1'b0);
  endtask

  task automatic t_lowpri();
    // R7: destination replaced by sender ID
    apply("R7", 8'd0, 1'b0, 2'd0, 8'd4, 3'd1, 1'b1, 1'b0);
    chk("R7", "mask_exact", 32'(out_mask), 32'h10);
    apply("R7", 8'hFF, 1'b1, 2'd0, 8'h02, 3'd1, 1'b1, 1'b0);
  endtask

  task automatic t_init();
    // R8: broadcast INIT overrides addressing
    apply("R8", 8'd9, 1'b0, 2'd1, 8'd12, 3'd5, 1'b1, 1'b0);
    chk("R8", "mask_exact", 32'(out_mask), 32'hFF);
    apply("R8", 8'd2, 1'b0, 2'd0, 8'd0, 3'd5, 1'b0, 1'b0);
  endtask

  task automatic t_deassert();
    // R9: de-assert loads arbitration IDs only
    apply("R9", 8'd2, 1'b0, 2'd0, 8'd0, 3'd5, 1'b0, 1'b1);
    chk("R9", "arb_exact", 32'(out_arb_load), 32'h04);
    apply("R9", 8'd0, 1'b0, 2'd3, 8'd6, 3'd5, 1'b0, 1'b1);
  endtask

  task automatic t_other();
    // R10: unsupported delivery modes
    apply("R10", 8'hFF, 1'b0, 2'd2, 8'd0, 3'd2, 1'b1, 1'b0);
    apply("R10", 8'd1, 1'b0, 2'd0, 8'd0, 3'd3, 1'b1, 1'b0);
    apply("R10", 8'hFF, 1'b0, 2'd0, 8'd0, 3'd4, 1'b1, 1'b0);
    apply("R10", 8'd3, 1'b0, 2'd2, 8'd0, 3'd6, 1'b0, 1'b1);
    apply("R10", 8'hFF, 1'b1, 2'd2, 8'd0, 3'd7, 1'b1, 1'b0);
  endtask

  task automatic t_hold();
    // R2: results stay after idle edges; valid drops
    apply("R2", 8'd5, 1'b0, 2'd0, 8'd0, 3'd0, 1'b1, 1'b0);
    req_dest = 8'd1;
    req_mode = 3'd5;
    repeat (3) @(negedge clk);
    chk("R2", "valid_idle", 32'(out_valid), 32'd0);
    chk("R2", "mask_held", 32'(out_mask), 32'h20);
    chk("R2", "init_held", 32'(out_init_all), 32'd0);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_dest = '0; req_logical = 1'b0;
    req_shorthand = '0; req_sender = '0; req_mode = '0; req_level = 1'b0;
    req_trigger = 1'b0; unit_ldr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_physical();
    t_logical();
    t_shorthand();
    t_lowpri();
    t_init();
    t_deassert();
    t_other();
    t_hold();
    summary();
  end

endmodule